// File: doc/BRIEF.md
# SPI Flash Block Erase Sequencer

This block is the host-side engine that erases one 64 KB block of a serial NOR flash attached over a single-data-line SPI link. A one-cycle start request carries an 8-bit block index. The block then runs the whole erase sequence on the serial pins without further help. First it sends a write-enable transaction. Next it sends the block-erase command with the block's 24-bit byte address. It then reads the status register again and again until the device reports that it is no longer busy. The block reports the outcome with a one-cycle done pulse and two error flags.

The serial clock is derived from the system clock by a parameterised half-period divider and idles low (SPI mode 0). Chip select is held high for a parameterised minimum number of system cycles between any two transactions. The number of status reads is bounded by a parameter. If the device is still busy after that many reads, a timeout is reported. The final status byte is also checked: if the write-enable latch is still set, a write-enable error is reported.

Top module: `spi_erase_seq`

## Requirements
- R1: Each accepted start first issues a write-enable transaction of exactly 8 clocks carrying opcode 0x06, and the erase transaction follows only after it.
- R2: The erase transaction shifts opcode 0xD8 and then a 24-bit address, MSB first. The address has the block index in bits 23:16 and zero in bits 15:0.
- R3: Every transaction has an exact count of rising serial-clock edges while chip select is low: 8 for write-enable, 32 for erase and 16 for a status read. Chip select rises with no further rising edge after the last bit.
- R4: A status read shifts opcode 0x05 and then clocks in one byte. Bit 0 of that byte is BUSY and bit 1 is the write-enable latch. Reads repeat until a byte with BUSY = 0 arrives.
- R5: The serial clock is low whenever chip select is high. MOSI changes only while the serial clock is low, and the device output is sampled on the rising edge.
- R6: Between any two transactions, chip select stays high for at least CS_GAP system clock cycles.
- R7: If POLL_LIMIT status reads in a row all return BUSY = 1, the sequence ends with err_timeout_o = 1. If BUSY clears on read POLL_LIMIT or earlier, err_timeout_o stays 0.
- R8: When the final status read returns BUSY = 0, err_wel_o takes that byte's bit 1. It is 1 exactly when the write-enable latch failed to clear.
- R9: done_o is high for exactly one cycle at the end of each sequence. busy_o is high from the cycle after an accepted start until done_o, and low afterwards. Both error flags are valid in the done_o cycle and hold until the next accepted start.
- R10: A start request that arrives while busy_o is high is ignored. It changes neither the address sent nor the transaction sequence, and it produces no extra done_o.
- R11: After reset: chip select high, serial clock low, MOSI low, busy_o, done_o and both error flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to erase a block |
| blk_i | input | 8 | Block index, sampled with start_i |
| spi_sclk_o | output | 1 | Serial clock to the flash |
| spi_cs_no | output | 1 | Active-low chip select |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_timeout_o | output | 1 | BUSY never cleared within POLL_LIMIT reads |
| err_wel_o | output | 1 | Write-enable latch still set at completion |

## Verification
The embedded properties assume the following about the inputs:
- start_i is a clean synchronous pulse.
- spi_miso_i is settled by the system clock edge that raises the serial clock.
- CS_GAP and POLL_LIMIT are at least 1.

The stimulus meets these assumptions in three ways:
- A behavioural flash model drives the data line only from its own bit count. The count advances after each rising serial edge, so the value is stable when sampled.
- start_i and blk_i change only on falling system-clock edges.
- The bench uses small parameter values: a divider of 2, a gap of 3 and a poll limit of 6. This lets a sweep of block indices and busy-read counts reach both sides of the timeout boundary.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;
  typedef enum logic [1:0] {OP_WREN, OP_ERASE, OP_RDSR} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_XFER} st_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_ERASE = 8'hD8;
  localparam logic [7:0] CMD_RDSR  = 8'h05;

  localparam int XFER_W     = 32;  // longest transaction: opcode + 24-bit address
  localparam int NBITS_W    = $clog2(XFER_W + 1);
  localparam int STS_W      = 2;   // only BUSY and WEL are kept
  localparam int STS_BUSY   = 0;
  localparam int STS_WEL    = 1;
  localparam int BLK_W      = 8;
  localparam int OFS_W      = 16;  // 64 KB block offset
  localparam int LEN_WREN   = 8;
  localparam int LEN_ERASE  = 32;
  localparam int LEN_RDSR   = 16;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_erase_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [XFER_W-1:0]  tx_i,
  input  logic [NBITS_W-1:0] nbits_i,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  output logic               done_o,
  output logic [STS_W-1:0]   rx_o
);
  logic               active_q, sclk_q, cs_q, done_q, tick;
  logic [XFER_W-1:0]  sh_q;
  logic [NBITS_W-1:0] left_q;
  logic [STS_W-1:0]   rx_q;

  spi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      done_q   <= 1'b0;
      sh_q     <= '0;
      left_q   <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          cs_q     <= 1'b0;
          sclk_q   <= 1'b0;
          sh_q     <= tx_i;
          left_q   <= nbits_i - 1'b1;
        end
      end else if (tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;                       // device samples, host samples
          rx_q   <= {rx_q[STS_W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (left_q == '0) begin               // last bit: end with no further edge
            active_q <= 1'b0;
            cs_q     <= 1'b1;
            done_q   <= 1'b1;
          end else begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign cs_no  = cs_q;
  assign mosi_o = !cs_q && sh_q[XFER_W-1];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // checker state: rising edges seen in the current transaction
  logic               sclk_d;
  logic [NBITS_W-1:0] edge_cnt, nb_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      edge_cnt <= '0;
      nb_q     <= '0;
    end else begin
      sclk_d <= sclk_q;
      if (go_i && !active_q) begin
        edge_cnt <= '0;
        nb_q     <= nbits_i;
      end else if (sclk_q && !sclk_d && !cs_q) begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  p_edge_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (edge_cnt == nb_q));
  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !sclk_q);
  p_mosi_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_q && $past(!cs_q) && sclk_q && $past(sclk_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
  import spi_erase_pkg::*;
#(
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 100000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [BLK_W-1:0]   blk_i,
  output logic               eng_go_o,
  output logic [XFER_W-1:0]  eng_tx_o,
  output logic [NBITS_W-1:0] eng_nbits_o,
  input  logic               eng_done_i,
  input  logic [STS_W-1:0]   eng_rx_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_timeout_o,
  output logic               err_wel_o
);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [GW-1:0] GAP_LAST  = GW'(CS_GAP - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  st_e             st_q;
  op_e             op_q;
  logic [GW-1:0]   gap_q;
  logic [PW-1:0]   poll_q;
  logic [BLK_W-1:0] blk_q;
  logic            done_q, e_to_q, e_wel_q, wren_ok_q;

  assign eng_go_o = (st_q == ST_GAP) && (gap_q == GAP_LAST);

  always_comb begin
    eng_tx_o    = '0;
    eng_nbits_o = '0;
    case (op_q)
      OP_WREN: begin
        eng_tx_o    = {CMD_WREN, 24'h0};
        eng_nbits_o = NBITS_W'(LEN_WREN);
      end
      OP_ERASE: begin
        eng_tx_o    = {CMD_ERASE, blk_q, OFS_W'(0)};
        eng_nbits_o = NBITS_W'(LEN_ERASE);
      end
      OP_RDSR: begin
        eng_tx_o    = {CMD_RDSR, 24'h0};
        eng_nbits_o = NBITS_W'(LEN_RDSR);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_WREN;
      gap_q     <= '0;
      poll_q    <= '0;
      blk_q     <= '0;
      done_q    <= 1'b0;
      e_to_q    <= 1'b0;
      e_wel_q   <= 1'b0;
      wren_ok_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q      <= ST_GAP;
          op_q      <= OP_WREN;
          gap_q     <= '0;
          poll_q    <= '0;
          blk_q     <= blk_i;
          e_to_q    <= 1'b0;
          e_wel_q   <= 1'b0;
          wren_ok_q <= 1'b0;
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) begin
            st_q  <= ST_XFER;
            gap_q <= '0;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_XFER: if (eng_done_i) begin
          case (op_q)
            OP_WREN: begin
              wren_ok_q <= 1'b1;
              op_q      <= OP_ERASE;
              st_q      <= ST_GAP;
            end
            OP_ERASE: begin
              op_q <= OP_RDSR;
              st_q <= ST_GAP;
            end
            default: begin
              if (!eng_rx_i[STS_BUSY]) begin
                e_wel_q <= eng_rx_i[STS_WEL];
                done_q  <= 1'b1;
                st_q    <= ST_IDLE;
              end else if (poll_q == POLL_LAST) begin
                e_to_q <= 1'b1;
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                poll_q <= poll_q + 1'b1;
                st_q   <= ST_GAP;
              end
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_timeout_o = e_to_q;
  assign err_wel_o     = e_wel_q;

  p_wren_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_go_o && op_q == OP_ERASE) |-> wren_ok_q);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (st_q == ST_IDLE));
  p_timeout_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(e_to_q) |-> done_q);
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(blk_q));
endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
  import spi_erase_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 100000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             spi_sclk_o,
  output logic             spi_cs_no,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_timeout_o,
  output logic             err_wel_o
);
  logic               go, eng_done;
  logic [XFER_W-1:0]  tx;
  logic [NBITS_W-1:0] nbits;
  logic [STS_W-1:0]   rx;

  spi_erase_ctrl #(.CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .blk_i        (blk_i),
    .eng_go_o     (go),
    .eng_tx_o     (tx),
    .eng_nbits_o  (nbits),
    .eng_done_i   (eng_done),
    .eng_rx_i     (rx),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_timeout_o(err_timeout_o),
    .err_wel_o    (err_wel_o)
  );

  spi_bit_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .tx_i   (tx),
    .nbits_i(nbits),
    .miso_i (spi_miso_i),
    .sclk_o (spi_sclk_o),
    .cs_no  (spi_cs_no),
    .mosi_o (spi_mosi_o),
    .done_o (eng_done),
    .rx_o   (rx)
  );

  // checker state: cycles chip select has been high, saturating at CS_GAP
  localparam int HW = $clog2(CS_GAP + 1);
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         hi_cnt <= '0;
    else if (!spi_cs_no)                 hi_cnt <= '0;
    else if (hi_cnt != HW'(CS_GAP))      hi_cnt <= hi_cnt + 1'b1;
  end

  p_cs_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> (hi_cnt == HW'(CS_GAP)));
endmodule

// File: tb/sim_spi_erase_seq.sv
`timescale 1ns/1ps
module sim_spi_erase_seq;
  localparam int HALF_DIV = 2;
  localparam int CS_GAP   = 3;
  localparam int PL       = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso;
  logic [7:0] blk = 8'h00;
  logic sclk, cs_n, mosi, busy, done, e_to, e_wel;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_erase_seq #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(PL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_i(blk),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .busy_o(busy), .done_o(done), .err_timeout_o(e_to), .err_wel_o(e_wel)
  );

  // ---------------- flash model ----------------
  logic [31:0] f_sh = '0;
  logic [7:0]  f_cmd = '0, f_snap = '0;
  int          f_bits = 0, f_busy_left = 0, f_nbusy = 0;
  bit          f_wel = 0, f_stuck = 0;
  logic [7:0]  tr_cmd [16];
  int          tr_bits [16];
  int          tr_n = 0, erase_cnt = 0;
  logic [23:0] erase_addr = '0;

  assign miso = (!cs_n && f_cmd == 8'h05 && f_bits >= 8 && f_bits < 16) ? f_snap[15 - f_bits] : 1'b0;

  always @(negedge cs_n) begin
    f_bits = 0; f_sh = '0; f_cmd = '0;
    f_snap = {6'b0, f_wel, (f_busy_left > 0)};
  end

  always @(posedge sclk) if (!cs_n) begin
    f_sh = {f_sh[30:0], mosi};
    f_bits++;
    if (f_bits == 8) f_cmd = f_sh[7:0];
  end

  always @(posedge cs_n) if (f_bits > 0) begin
    if (tr_n < 16) begin tr_cmd[tr_n] = f_cmd; tr_bits[tr_n] = f_bits; end
    tr_n++;
    if (f_cmd == 8'h06 && f_bits == 8) f_wel = 1;
    else if (f_cmd == 8'hD8 && f_bits == 32 && f_wel) begin
      erase_cnt++; erase_addr = f_sh[23:0]; f_busy_left = f_nbusy;
      if (f_nbusy == 0) f_wel = f_stuck;
    end else if (f_cmd == 8'h05 && f_busy_left > 0) begin
      f_busy_left--;
      if (f_busy_left == 0) f_wel = f_stuck;
    end
  end

  // ---------------- pin monitors ----------------
  int hi_run = 0, min_gap = 1000000, idle_bad = 0, mosi_bad = 0;
  logic p_sclk = 0, p_cs = 1, p_mosi = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n) hi_run++;
    else begin
      if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
    if (cs_n && sclk) idle_bad++;
    if (!cs_n && !p_cs && sclk && p_sclk && mosi != p_mosi) mosi_bad++;
    p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] b, input int nbusy, input bit stuck, input bit poke);
    int cyc = 0, ndone = 0, reads, n_after;
    bit seen = 0, to_exp;
    f_busy_left = 0; f_wel = 0; f_stuck = stuck; f_nbusy = nbusy;
    tr_n = 0; erase_cnt = 0; erase_addr = '1; min_gap = 1000000;
    @(negedge clk); start = 1; blk = b;
    @(negedge clk); start = 0; blk = 8'hEE;
    chk(busy === 1'b1, "R9 busy after start", busy, 1);
    while (!seen && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (poke && cyc == 100) begin start = 1; blk = 8'h33; end
      if (poke && cyc == 101) start = 0;
      if (poke && cyc == 400) begin start = 1; blk = 8'h44; end
      if (poke && cyc == 401) start = 0;
      if (done) begin seen = 1; ndone++; end
    end
    chk(seen, "R9 done seen", seen, 1);
    to_exp = (nbusy >= PL);
    reads  = to_exp ? PL : nbusy + 1;
    chk(e_to == to_exp, "R7 timeout flag", e_to, to_exp);
    chk(e_wel == (!to_exp && stuck), "R8 wel flag", e_wel, (!to_exp && stuck));
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", done, 0);
    chk(busy == 1'b0, "R9 busy low after done", busy, 0);
    chk(e_to == to_exp && e_wel == (!to_exp && stuck), "R9 flags hold", {e_to, e_wel}, {to_exp, (!to_exp && stuck)});
    n_after = tr_n;
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(tr_n == n_after && cs_n, "R10 no extra transaction", tr_n, n_after);
      chk(ndone == 1, "R10 single done", ndone, 1);
    end
    chk(tr_n == 2 + reads, "R4 transaction count", tr_n, 2 + reads);
    chk(tr_cmd[0] == 8'h06 && tr_bits[0] == 8, "R1 wren first", {tr_cmd[0], 8'(tr_bits[0])}, 16'h0608);
    chk(tr_cmd[1] == 8'hD8 && tr_bits[1] == 32, "R3 erase edges", {tr_cmd[1], 8'(tr_bits[1])}, 16'hD820);
    chk(erase_cnt == 1, "R1 erase accepted", erase_cnt, 1);
    chk(erase_addr == {b, 16'h0000}, "R2 erase address", erase_addr, {b, 16'h0000});
    for (int i = 2; i < tr_n && i < 16; i++)
      chk(tr_cmd[i] == 8'h05 && tr_bits[i] == 16, "R4 status read", {tr_cmd[i], 8'(tr_bits[i])}, 16'h0510);
    chk(min_gap >= CS_GAP, "R6 cs gap", min_gap, CS_GAP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] blks [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R11 pins at reset", {cs_n, sclk, mosi}, 3'b100);
    chk(busy === 1'b0 && done === 1'b0 && e_to === 1'b0 && e_wel === 1'b0, "R11 status at reset",
        {busy, done, e_to, e_wel}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R11 idle after release", {cs_n, busy}, 2'b10);
    foreach (blks[k])
      for (int nb = 0; nb <= PL + 1; nb++) run(blks[k], nb, 1'b0, 1'b0);
    for (int nb = 0; nb < PL; nb += 2) run(8'hC3, nb, 1'b1, 1'b0);
    run(8'h3C, 3, 1'b0, 1'b1);
    run(8'h7E, PL + 2, 1'b1, 1'b1);
    chk(idle_bad == 0, "R5 sclk idle low", idle_bad, 0);
    chk(mosi_bad == 0, "R5 mosi stable while sclk high", mosi_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule